// File: doc/BRIEF.md
# MOESI Line Coherence Controller

This block keeps the coherence state of a small set of cache lines, one five-state machine per line. Local requests (read, write, evict) arrive from the cache side. Snoop requests arrive from the system side. Each snoop is answered one cycle later with a response that says whether the line was held, whether it was dirty, and whether this cache hands over the line's data. The data arrays, channel handshakes and memory are outside the block. It only decides the states, the snoop answers, the write-back requests and the upgrade requests.

A front-end gate screens every snoop before it reaches the lines. A snoop takes part in coherence only when the modifiable bit (bit 1) of its 4-bit cache attribute is set and its 2-bit domain is inner (01) or outer (10) shareable. A modifiable snoop that carries the reserved domain 11 raises an error flag and changes nothing.

Each line moves between its states as follows. Invalid goes to Exclusive or Shared on a read miss. Exclusive goes to Modified on a silent write. Invalid, Shared and Owned go to Modified on a write that also raises an upgrade request. Modified goes to Owned on a shared-read snoop, and Exclusive goes to Shared on the same snoop. Every state goes to Invalid on a unique snoop. Every state goes to Invalid on eviction, and a dirty line (Modified or Owned) that is evicted raises a write-back request.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid and all response, error, write-back and upgrade outputs are 0.
- R2: `peek_state` shows, without delay, the state of line `peek_idx` encoded as Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4.
- R3: Local op codes are 00 read, 01 write, 10 evict and 11 no-op. A read of an Invalid line moves it to Exclusive when `loc_other_holder` is 0 and to Shared when it is 1. A read of a valid line, and any no-op, leaves the state unchanged.
- R4: A local write leaves the line Modified. From Exclusive or Modified no upgrade request is raised. From Invalid, Shared or Owned, `upg_req` pulses one cycle later with `upg_idx` equal to the line index.
- R5: An eviction leaves the line Invalid. From Modified or Owned, `wb_req` pulses one cycle later with `wb_idx` equal to the line index. From Shared or Exclusive no write-back is raised.
- R6: A snoop with attribute bit 1 clear, or with domain 00, changes no state and is answered with `rsp_valid`=1 and present, dirty and supply all 0.
- R7: A snoop with attribute bit 1 set and domain 11 sets `rsp_err` one cycle later and changes no state. Otherwise `rsp_err` is 0.
- R8: Read code 0100 (shared read, `snp_is_write`=0) moves Modified to Owned and Exclusive to Shared, and leaves Owned and Shared unchanged. Data is supplied when the line was Modified or Owned.
- R9: Read code 0101 (unique read) moves any line to Invalid. Data is supplied when the line was dirty.
- R10: Read code 0001 (one-time read) leaves the state unchanged. Data is supplied when the line was dirty.
- R11: Write code 001 (unique write, `snp_is_write`=1) moves any line to Invalid and supplies data when the line was dirty. Write code 011 (write-back) leaves the state unchanged and never supplies data.
- R12: `rsp_valid` pulses one cycle after each snoop. `rsp_present` is set when the pre-snoop state was not Invalid, and `rsp_dirty` is set when it was Modified or Owned. An Invalid line, or an unrecognised code, gives all flags clear, and an unrecognised code changes no state.
- R13: When an acting snoop and a local request target the same line in one cycle, the snoop is applied and the local request is dropped, so no write-back or upgrade is raised for it. Requests to different lines both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local request present |
| loc_op | input | 2 | Local op: 00 read, 01 write, 10 evict, 11 no-op |
| loc_idx | input | IDX_W | Line targeted by the local request |
| loc_other_holder | input | 1 | Read miss: another cache reports a copy |
| snp_valid | input | 1 | Snoop present |
| snp_is_write | input | 1 | Selects the write code (1) or the read code (0) |
| snp_rd_code | input | 4 | Read snoop code |
| snp_wr_code | input | 3 | Write snoop code |
| snp_attr | input | 4 | Cache attribute; bit 1 is the modifiable bit |
| snp_domain | input | 2 | Shareability domain |
| snp_idx | input | IDX_W | Line targeted by the snoop |
| rsp_valid | output | 1 | Snoop response strobe |
| rsp_present | output | 1 | Line was held |
| rsp_dirty | output | 1 | Line was dirty |
| rsp_supply | output | 1 | This cache transfers the data |
| rsp_err | output | 1 | Illegal domain on a modifiable snoop |
| wb_req | output | 1 | Write-back request pulse |
| wb_idx | output | IDX_W | Line to write back |
| upg_req | output | 1 | Upgrade (invalidate others) request pulse |
| upg_idx | output | IDX_W | Line being upgraded |
| peek_idx | input | IDX_W | Line whose state is shown |
| peek_state | output | 3 | State of line `peek_idx` |

## Verification
Every one of the five starting states is paired with each of the six snoop codes: shared read, unique read, one-time read, unique write, write-back and one unrecognised code. This separates the snoops that downgrade, the ones that invalidate and the ones that leave the state alone. Supply and dirty are told apart because write-back sees a dirty line yet must not supply. The same five states meet every local op (read with and without another holder, write, evict, no-op), so silent upgrades are separated from upgrades that must be requested. Gating is probed with the modifiable bit cleared, with the non-shareable domain and with the reserved domain. Simultaneous local and snoop requests are tried on the same line and on different lines.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        LS_INV = 3'd0,
        LS_SHR = 3'd1,
        LS_EXC = 3'd2,
        LS_OWN = 3'd3,
        LS_MOD = 3'd4
    } line_state_e;

    typedef enum logic [2:0] {
        SK_NONE    = 3'd0,
        SK_RD_SHR  = 3'd1,
        SK_RD_UNQ  = 3'd2,
        SK_RD_ONCE = 3'd3,
        SK_WR_UNQ  = 3'd4,
        SK_WR_BACK = 3'd5
    } snoop_kind_e;

    typedef enum logic [1:0] {
        LO_READ  = 2'd0,
        LO_WRITE = 2'd1,
        LO_EVICT = 2'd2,
        LO_NOP   = 2'd3
    } local_op_e;

    localparam int ATTR_W  = 4;
    localparam int MOD_BIT = 1;
    localparam int RCODE_W = 4;
    localparam int WCODE_W = 3;

    localparam logic [RCODE_W-1:0] RC_SHARED = 4'b0100;
    localparam logic [RCODE_W-1:0] RC_UNIQUE = 4'b0101;
    localparam logic [RCODE_W-1:0] RC_ONCE   = 4'b0001;
    localparam logic [WCODE_W-1:0] WC_UNIQUE = 3'b001;
    localparam logic [WCODE_W-1:0] WC_BACK   = 3'b011;

    localparam logic [1:0] DOM_NONSH = 2'b00;
    localparam logic [1:0] DOM_INNER = 2'b01;
    localparam logic [1:0] DOM_OUTER = 2'b10;
    localparam logic [1:0] DOM_BAD   = 2'b11;

    function automatic logic st_dirty(line_state_e s);
        return (s == LS_MOD) || (s == LS_OWN);
    endfunction

endpackage

// File: rtl/coh_snoop_gate.sv
module coh_snoop_gate
    import coh_pkg::*;
(
    input  logic               snp_valid,
    input  logic               snp_is_write,
    input  logic [RCODE_W-1:0] snp_rd_code,
    input  logic [WCODE_W-1:0] snp_wr_code,
    input  logic [ATTR_W-1:0]  snp_attr,
    input  logic [1:0]         snp_domain,
    output logic               act,
    output logic               err,
    output snoop_kind_e        kind
);

    logic modifiable;
    logic dom_ok;
    logic unused_attr;

    assign modifiable  = snp_attr[MOD_BIT];
    assign unused_attr = ^snp_attr;
    assign dom_ok      = (snp_domain == DOM_INNER) || (snp_domain == DOM_OUTER);

    always_comb begin
        kind = SK_NONE;
        if (snp_is_write) begin
            if (snp_wr_code == WC_UNIQUE)     kind = SK_WR_UNQ;
            else if (snp_wr_code == WC_BACK)  kind = SK_WR_BACK;
        end else begin
            if (snp_rd_code == RC_SHARED)      kind = SK_RD_SHR;
            else if (snp_rd_code == RC_UNIQUE) kind = SK_RD_UNQ;
            else if (snp_rd_code == RC_ONCE)   kind = SK_RD_ONCE;
        end
    end

    assign act = snp_valid && modifiable && dom_ok && (kind != SK_NONE);
    assign err = snp_valid && modifiable && (snp_domain == DOM_BAD);

    // R7
    always_comb begin
        err_excl_chk: assert (!(act && err));
    end

endmodule

// File: rtl/coh_line_fsm.sv
module coh_line_fsm
    import coh_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        snp_en,
    input  snoop_kind_e snp_kind,
    input  logic        loc_en,
    input  local_op_e   loc_op,
    input  logic        loc_other,
    output line_state_e state_o,
    output logic        evt_wb,
    output logic        evt_upg
);

    line_state_e state_q;
    line_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_INV;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (snp_en) begin
            unique case (snp_kind)
                SK_RD_SHR: begin
                    if (state_q == LS_MOD)      state_d = LS_OWN;
                    else if (state_q == LS_EXC) state_d = LS_SHR;
                end
                SK_RD_UNQ,
                SK_WR_UNQ: state_d = LS_INV;
                default:   state_d = state_q;
            endcase
        end else if (loc_en) begin
            unique case (loc_op)
                LO_READ: begin
                    if (state_q == LS_INV) state_d = loc_other ? LS_SHR : LS_EXC;
                end
                LO_WRITE: state_d = LS_MOD;
                LO_EVICT: state_d = LS_INV;
                LO_NOP:   state_d = state_q;
            endcase
        end
    end

    always_comb begin
        evt_wb  = 1'b0;
        evt_upg = 1'b0;
        if (loc_en && !snp_en) begin
            evt_wb  = (loc_op == LO_EVICT) && st_dirty(state_q);
            evt_upg = (loc_op == LO_WRITE) &&
                      (state_q != LS_EXC) && (state_q != LS_MOD);
        end
    end

    assign state_o = state_q;

    // R4
    exc_silent_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_en && !snp_en && loc_op == LO_WRITE && state_q == LS_EXC) |=> state_q == LS_MOD);

    // R9
    unq_snoop_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_en && (snp_kind == SK_RD_UNQ || snp_kind == SK_WR_UNQ)) |=> state_q == LS_INV);

    // R10
    once_snoop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_en && snp_kind == SK_RD_ONCE) |=> $stable(state_q));

    // R5
    evict_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_en && !snp_en && loc_op == LO_EVICT) |=> state_q == LS_INV);

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter  int NUM_LINES = 8,
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loc_valid,
    input  logic [1:0]         loc_op,
    input  logic [IDX_W-1:0]   loc_idx,
    input  logic               loc_other_holder,
    input  logic               snp_valid,
    input  logic               snp_is_write,
    input  logic [3:0]         snp_rd_code,
    input  logic [2:0]         snp_wr_code,
    input  logic [3:0]         snp_attr,
    input  logic [1:0]         snp_domain,
    input  logic [IDX_W-1:0]   snp_idx,
    output logic               rsp_valid,
    output logic               rsp_present,
    output logic               rsp_dirty,
    output logic               rsp_supply,
    output logic               rsp_err,
    output logic               wb_req,
    output logic [IDX_W-1:0]   wb_idx,
    output logic               upg_req,
    output logic [IDX_W-1:0]   upg_idx,
    input  logic [IDX_W-1:0]   peek_idx,
    output logic [2:0]         peek_state
);

    logic        snp_act;
    logic        snp_err;
    snoop_kind_e snp_kind;

    line_state_e          line_st [NUM_LINES];
    logic [NUM_LINES-1:0] snp_en;
    logic [NUM_LINES-1:0] loc_en;
    logic [NUM_LINES-1:0] evt_wb;
    logic [NUM_LINES-1:0] evt_upg;
    line_state_e          snp_sel_st;
    line_state_e          peek_sel_st;
    local_op_e            loc_op_e;

    assign loc_op_e = local_op_e'(loc_op);

    coh_snoop_gate u_gate (
        .snp_valid    (snp_valid),
        .snp_is_write (snp_is_write),
        .snp_rd_code  (snp_rd_code),
        .snp_wr_code  (snp_wr_code),
        .snp_attr     (snp_attr),
        .snp_domain   (snp_domain),
        .act          (snp_act),
        .err          (snp_err),
        .kind         (snp_kind)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign snp_en[g] = snp_act && (snp_idx == IDX_W'(g));
        assign loc_en[g] = loc_valid && (loc_idx == IDX_W'(g)) && !snp_en[g];

        coh_line_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .snp_en    (snp_en[g]),
            .snp_kind  (snp_kind),
            .loc_en    (loc_en[g]),
            .loc_op    (loc_op_e),
            .loc_other (loc_other_holder),
            .state_o   (line_st[g]),
            .evt_wb    (evt_wb[g]),
            .evt_upg   (evt_upg[g])
        );
    end

    always_comb begin
        snp_sel_st  = LS_INV;
        peek_sel_st = LS_INV;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (snp_idx == IDX_W'(i))  snp_sel_st  = line_st[i];
            if (peek_idx == IDX_W'(i)) peek_sel_st = line_st[i];
        end
    end

    assign peek_state = peek_sel_st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_present <= 1'b0;
            rsp_dirty   <= 1'b0;
            rsp_supply  <= 1'b0;
            rsp_err     <= 1'b0;
            wb_req      <= 1'b0;
            wb_idx      <= '0;
            upg_req     <= 1'b0;
            upg_idx     <= '0;
        end else begin
            rsp_valid   <= snp_valid;
            rsp_present <= snp_act && (snp_sel_st != LS_INV);
            rsp_dirty   <= snp_act && st_dirty(snp_sel_st);
            rsp_supply  <= snp_act && st_dirty(snp_sel_st) && (snp_kind != SK_WR_BACK);
            rsp_err     <= snp_err;
            wb_req      <= |evt_wb;
            wb_idx      <= loc_idx;
            upg_req     <= |evt_upg;
            upg_idx     <= loc_idx;
        end
    end

    // R12
    rsp_follows_snp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> rsp_valid);

    // R12
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !rsp_valid);

    // R12
    dirty_needs_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_dirty |-> rsp_present);

    // R11
    supply_needs_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_supply |-> rsp_dirty);

    // R7
    err_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !rsp_present);

    // R13
    one_local_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wb_req, upg_req}) <= 1);

endmodule

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;

    localparam int CLK_P = 10;
    localparam int NL    = 8;
    localparam int IW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          loc_valid = 1'b0;
    logic [1:0]    loc_op = 2'd3;
    logic [IW-1:0] loc_idx = '0;
    logic          loc_other_holder = 1'b0;
    logic          snp_valid = 1'b0;
    logic          snp_is_write = 1'b0;
    logic [3:0]    snp_rd_code = '0;
    logic [2:0]    snp_wr_code = '0;
    logic [3:0]    snp_attr = '0;
    logic [1:0]    snp_domain = '0;
    logic [IW-1:0] snp_idx = '0;
    logic          rsp_valid, rsp_present, rsp_dirty, rsp_supply, rsp_err;
    logic          wb_req, upg_req;
    logic [IW-1:0] wb_idx, upg_idx;
    logic [IW-1:0] peek_idx = '0;
    logic [2:0]    peek_state;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    coh_line_ctrl #(.NUM_LINES(NL)) uut (
        .clk(clk), .rst_n(rst_n),
        .loc_valid(loc_valid), .loc_op(loc_op), .loc_idx(loc_idx),
        .loc_other_holder(loc_other_holder),
        .snp_valid(snp_valid), .snp_is_write(snp_is_write),
        .snp_rd_code(snp_rd_code), .snp_wr_code(snp_wr_code),
        .snp_attr(snp_attr), .snp_domain(snp_domain), .snp_idx(snp_idx),
        .rsp_valid(rsp_valid), .rsp_present(rsp_present), .rsp_dirty(rsp_dirty),
        .rsp_supply(rsp_supply), .rsp_err(rsp_err),
        .wb_req(wb_req), .wb_idx(wb_idx), .upg_req(upg_req), .upg_idx(upg_idx),
        .peek_idx(peek_idx), .peek_state(peek_state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_snoop(input int idx, input int v, input logic [3:0] at, input logic [1:0] dm);
        snp_valid = 1'b1;
        snp_idx   = IW'(idx);
        snp_attr  = at;
        snp_domain = dm;
        snp_is_write = (v == 3 || v == 4);
        case (v)
            0: snp_rd_code = 4'b0100;
            1: snp_rd_code = 4'b0101;
            2: snp_rd_code = 4'b0001;
            5: snp_rd_code = 4'b0010;
            default: snp_rd_code = 4'b0000;
        endcase
        snp_wr_code = (v == 3) ? 3'b001 : (v == 4) ? 3'b011 : 3'b000;
    endtask

    task automatic set_local(input int idx, input int op, input bit oth);
        loc_valid = 1'b1;
        loc_idx = IW'(idx);
        loc_op = 2'(op);
        loc_other_holder = oth;
    endtask

    task automatic release_all;
        snp_valid = 1'b0;
        loc_valid = 1'b0;
        loc_op = 2'd3;
    endtask

    task automatic do_snoop(input int idx, input int v, input logic [3:0] at, input logic [1:0] dm);
        @(negedge clk);
        set_snoop(idx, v, at, dm);
        @(negedge clk);
        release_all();
    endtask

    task automatic do_local(input int idx, input int op, input bit oth);
        @(negedge clk);
        set_local(idx, op, oth);
        @(negedge clk);
        release_all();
    endtask

    // states: 0 I, 1 S, 2 E, 3 O, 4 M
    task automatic set_state(input int idx, input int st);
        do_local(idx, 2, 1'b0);
        case (st)
            1: do_local(idx, 0, 1'b1);
            2: do_local(idx, 0, 1'b0);
            3: begin
                do_local(idx, 0, 1'b0);
                do_local(idx, 1, 1'b0);
                do_snoop(idx, 0, 4'b0010, 2'b01);
            end
            4: begin
                do_local(idx, 0, 1'b0);
                do_local(idx, 1, 1'b0);
            end
            default: ;
        endcase
    endtask

    function automatic string kind_tag(input int v);
        case (v)
            0: return "R8";
            1: return "R9";
            2: return "R10";
            3, 4: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic int snp_next(input int st, input int v);
        if (v == 0) return (st == 4) ? 3 : (st == 2) ? 1 : st;
        if (v == 1 || v == 3) return 0;
        return st;
    endfunction

    function automatic int loc_next(input int st, input int op, input bit oth);
        case (op)
            0: return (st == 0) ? (oth ? 1 : 2) : st;
            1: return 4;
            2: return 0;
            default: return st;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: reset state
        for (int i = 0; i < NL; i++) begin
            peek_idx = IW'(i);
            #1;
            chk("R1 R2 reset line state", peek_state, 0);
        end
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsp_err", rsp_err, 0);
        chk("R1 wb_req", wb_req, 0);
        chk("R1 upg_req", upg_req, 0);

        // snoop sweep: every state x every code
        for (int st = 0; st < 5; st++) begin
            for (int v = 0; v < 6; v++) begin
                int idx;
                int dirty;
                idx = (st + v) % NL;
                dirty = (v != 5) && (st == 3 || st == 4);
                set_state(idx, st);
                peek_idx = IW'(idx);
                do_snoop(idx, v, 4'b0010, (v % 2 == 1) ? 2'b10 : 2'b01);
                chk("R12 rsp_valid", rsp_valid, 1);
                chk("R12 rsp_present", rsp_present, (v != 5 && st != 0) ? 1 : 0);
                chk("R12 rsp_dirty", rsp_dirty, dirty);
                chk({kind_tag(v), " rsp_supply"}, rsp_supply, (dirty && v != 4) ? 1 : 0);
                chk("R7 rsp_err clear", rsp_err, 0);
                chk({kind_tag(v), " next state"}, peek_state, snp_next(st, v));
            end
        end

        // local sweep: every state x every op
        for (int st = 0; st < 5; st++) begin
            for (int k = 0; k < 5; k++) begin
                int op;
                bit oth;
                int idx;
                string tg;
                op  = (k == 0 || k == 1) ? 0 : k - 1;
                oth = (k == 1);
                idx = (st * 3 + k) % NL;
                tg  = (op == 1) ? "R4" : (op == 2) ? "R5" : "R3";
                set_state(idx, st);
                peek_idx = IW'(idx);
                do_local(idx, op, oth);
                chk({tg, " local next state"}, peek_state, loc_next(st, op, oth));
                chk({tg, " wb_req"}, wb_req, (op == 2 && (st == 3 || st == 4)) ? 1 : 0);
                chk({tg, " upg_req"}, upg_req, (op == 1 && (st == 0 || st == 1 || st == 3)) ? 1 : 0);
                if (wb_req)  chk("R5 wb_idx", wb_idx, idx);
                if (upg_req) chk("R4 upg_idx", upg_idx, idx);
            end
        end

        // R6: gating
        set_state(5, 4);
        peek_idx = IW'(5);
        do_snoop(5, 1, 4'b1101, 2'b01);
        chk("R6 bypass rsp_valid", rsp_valid, 1);
        chk("R6 bypass present", rsp_present, 0);
        chk("R6 bypass supply", rsp_supply, 0);
        chk("R6 bypass state", peek_state, 4);
        do_snoop(5, 1, 4'b0010, 2'b00);
        chk("R6 nonshare present", rsp_present, 0);
        chk("R6 nonshare dirty", rsp_dirty, 0);
        chk("R6 nonshare state", peek_state, 4);

        // R7: illegal domain
        do_snoop(5, 1, 4'b0010, 2'b11);
        chk("R7 err set", rsp_err, 1);
        chk("R7 err no present", rsp_present, 0);
        chk("R7 err state", peek_state, 4);
        @(negedge clk);
        chk("R7 err clears", rsp_err, 0);
        do_snoop(5, 1, 4'b1101, 2'b11);
        chk("R7 non-modifiable no err", rsp_err, 0);
        chk("R7 non-modifiable state", peek_state, 4);

        // R13: same-line collision
        set_state(2, 4);
        peek_idx = IW'(2);
        @(negedge clk);
        set_snoop(2, 1, 4'b0010, 2'b01);
        set_local(2, 2, 1'b0);
        @(negedge clk);
        release_all();
        chk("R13 collision state", peek_state, 0);
        chk("R13 collision wb dropped", wb_req, 0);
        chk("R13 collision supply", rsp_supply, 1);

        // R13: different lines
        set_state(1, 2);
        set_state(3, 4);
        @(negedge clk);
        set_snoop(3, 0, 4'b0010, 2'b10);
        set_local(1, 1, 1'b0);
        @(negedge clk);
        release_all();
        chk("R13 parallel upg silent", upg_req, 0);
        chk("R13 parallel supply", rsp_supply, 1);
        peek_idx = IW'(1);
        #1;
        chk("R13 parallel local state", peek_state, 4);
        peek_idx = IW'(3);
        #1;
        chk("R13 parallel snoop state", peek_state, 3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule